// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache with Store Queue

The block is a direct-mapped data cache that keeps one data word per line and sits between a processor load/store port and a memory port. Loads that find their line valid with a matching tag return data in the same cycle. Loads that miss hold the processor with a stall signal while the word is fetched from memory and installed. Every store writes the cache and is also placed, with its word address, into a small first-in first-out store queue. The queue drains to memory on its own write channel, one word per handshake.

The processor stalls only for a fetch, or when a store meets a full queue. A store that misses fetches its line first and then writes into it. A fetch is held back while the queue still holds a store to the same word, so memory never returns data older than a store the processor has already done.

The processor holds its request, address and write data steady while the stall output is high. An access completes on the clock edge where the request is high and the stall is low.

Top module: `dm_wt_cache`

## Requirements
- R1: With the default parameters, address bits [1:0] are a byte offset that has no effect on which word is accessed, bits [11:2] select one of 1024 lines, and bits [31:12] form the tag. In general the index is INDEX_W bits starting at bit 2, and the tag is every bit above the index.
- R2: After reset no line is valid, so the first access to any line is a miss that issues a memory read. Also after reset, neither memory request is active and the stall output is low while no request is present.
- R3: A read miss raises the stall and issues exactly one memory read of the word address, with the low two address bits zero. The read address is held until the read response. The word is installed, and the access then completes and returns the fetched word.
- R4: A read whose line is valid with an equal tag completes in the cycle it is presented, with no stall, no memory read, and the stored word on the read data output.
- R5: A store that hits while the queue has a free entry completes with no stall. It updates the cached word, which a later read returns, and it adds one entry to the queue.
- R6: The queue holds WB_DEPTH entries and drains them in the order the stores completed. Each entry is one memory write, and its address and data stay stable until the write is acknowledged.
- R7: A store presented while the queue is full stalls until an entry drains. No entry is ever lost or overwritten.
- R8: A store that misses first fetches the line with one memory read and then writes its data into the line, so a following read of that address hits and returns the stored data.
- R9: A memory read is never issued while the queue holds a store to the same word address. The fetch waits until that store has drained, so the fetched word reflects the store.
- R10: Two addresses with the same index but different tags evict each other, and each access after an eviction misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid in the completing cycle |
| cpu_stall | output | 1 | Processor must hold its request this cycle |
| mem_rd_req | output | 1 | Line fetch request, held until response |
| mem_rd_addr | output | ADDR_W | Word-aligned fetch address |
| mem_rd_valid | input | 1 | One-cycle fetch response strobe |
| mem_rd_data | input | DATA_W | Fetched word |
| mem_wr_req | output | 1 | Queue head write request |
| mem_wr_addr | output | ADDR_W | Word-aligned address of the queue head |
| mem_wr_data | output | DATA_W | Data of the queue head |
| mem_wr_ack | input | 1 | One-cycle write acknowledge, pops the head |

## Verification
The bench builds the cache with INDEX_W = 4, which gives 16 lines with a 26-bit tag, and WB_DEPTH = 4. Every line can be swept for cold misses, hits, byte-offset aliasing and tag conflicts, and the expected outcome of each access comes from a small model of the line array. The four-entry queue fills after four stores, so the full-queue stall is reached quickly. With a memory write latency that can be changed at run time, the bench makes the queue drain slowly. The same-word fetch hazard then occurs, and so does the full-queue stall.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

   typedef enum logic [0:0] {
      ST_LOOKUP = 1'b0,
      ST_FILL   = 1'b1
   } wtc_state_e;

endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
   parameter int INDEX_W = 10,
   parameter int TAG_W   = 20,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INDEX_W-1:0] lk_index,
   input  logic [TAG_W-1:0]   lk_tag,
   output logic               lk_hit,
   output logic [DATA_W-1:0]  lk_data,
   input  logic               wr_en,
   input  logic [INDEX_W-1:0] wr_index,
   input  logic [TAG_W-1:0]   wr_tag,
   input  logic [DATA_W-1:0]  wr_data
);

   localparam int LINES = 1 << INDEX_W;

   if (INDEX_W < 1 || INDEX_W > 12) begin : g_bad_index
      $error("wtc_line_store: INDEX_W must be 1..12");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wtc_line_store: TAG_W must be at least 1");
   end

   logic [LINES-1:0]  valid_q;
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [DATA_W-1:0] data_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_index] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_index]  <= wr_tag;
         data_q[wr_index] <= wr_data;
      end
   end

   assign lk_hit  = valid_q[lk_index] && (tag_q[lk_index] == lk_tag);
   assign lk_data = data_q[lk_index];

endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
   parameter int WA_W   = 30,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WA_W-1:0]   push_addr,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic              full,
   output logic              empty,
   output logic [WA_W-1:0]   head_addr,
   output logic [DATA_W-1:0] head_data,
   input  logic [WA_W-1:0]   probe_addr,
   output logic              probe_hit
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = PTR_W + 1;
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   if (DEPTH < 2 || DEPTH > 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wtc_wbuf: DEPTH must be 2, 4 or 8");
   end

   logic [WA_W-1:0]   addr_q [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DEPTH-1:0]  slot_match;

   assign full  = (cnt_q == DEPTH_C);
   assign empty = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr_q <= '0;
         wr_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[wr_ptr_q] <= push_addr;
         data_q[wr_ptr_q] <= push_data;
      end
   end

   assign head_addr = addr_q[rd_ptr_q];
   assign head_data = data_q[rd_ptr_q];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      localparam logic [PTR_W-1:0] SLOT = PTR_W'(i);
      logic [PTR_W-1:0] rel;
      logic             occupied;
      assign rel           = SLOT - rd_ptr_q;
      assign occupied      = ({1'b0, rel} < cnt_q);
      assign slot_match[i] = occupied && (addr_q[i] == probe_addr);
   end

   assign probe_hit = |slot_match;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop)) else $error("queue overflow"); // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty) else $error("queue underflow"); // R6
   AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !pop) |=> (!empty && $stable(head_addr) && $stable(head_data)))
      else $error("queue head changed before acknowledge"); // R6

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
   import wtc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_req,
   input  logic cpu_we,
   input  logic line_hit,
   input  logic wb_full,
   input  logic wb_hazard,
   input  logic mem_rd_valid,
   output logic cpu_stall,
   output logic fill_req,
   output logic install_en,
   output logic store_en
);

   wtc_state_e state_q, state_d;
   logic       miss;

   assign miss = cpu_req && !line_hit;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_LOOKUP: if (miss && !wb_hazard) state_d = ST_FILL;
         ST_FILL:   if (mem_rd_valid)       state_d = ST_LOOKUP;
         default:   state_d = ST_LOOKUP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_LOOKUP;
      else        state_q <= state_d;
   end

   assign fill_req   = (state_q == ST_FILL);
   assign install_en = (state_q == ST_FILL) && mem_rd_valid;
   assign cpu_stall  = cpu_req && (!line_hit || (cpu_we && wb_full));
   assign store_en   = (state_q == ST_LOOKUP) && cpu_req && cpu_we && line_hit && !wb_full;

   AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we && line_hit) |-> !cpu_stall) else $error("load hit stalled"); // R4
   AST_FILL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      install_en |=> !fill_req) else $error("fetch did not end after response"); // R3

endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int INDEX_W  = 10,
   parameter int WB_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   input  logic              mem_wr_ack
);

   localparam int OFF_W = $clog2(DATA_W / 8);
   localparam int WA_W  = ADDR_W - OFF_W;
   localparam int TAG_W = ADDR_W - INDEX_W - OFF_W;

   if (DATA_W < 16 || (DATA_W % 8) != 0 || ((DATA_W / 8) & (DATA_W / 8 - 1)) != 0) begin : g_bad_data
      $error("dm_wt_cache: DATA_W must be a power-of-two number of bytes, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_split
      $error("dm_wt_cache: ADDR_W too small for INDEX_W");
   end

   logic [INDEX_W-1:0] idx;
   logic [TAG_W-1:0]   tag;
   logic [WA_W-1:0]    word_addr;
   logic               line_hit;
   logic [DATA_W-1:0]  line_data;
   logic               wb_full, wb_empty, wb_hazard;
   logic [WA_W-1:0]    wb_head_addr;
   logic               install_en, store_en, fill_req;
   logic               arr_wr_en;
   logic [DATA_W-1:0]  arr_wr_data;
   wire                unused_offset_bits = ^cpu_addr[OFF_W-1:0];

   assign idx       = cpu_addr[OFF_W +: INDEX_W];
   assign tag       = cpu_addr[ADDR_W-1 -: TAG_W];
   assign word_addr = cpu_addr[ADDR_W-1:OFF_W];

   assign arr_wr_en   = install_en || store_en;
   assign arr_wr_data = install_en ? mem_rd_data : cpu_wdata;

   wtc_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_index (idx),
      .lk_tag   (tag),
      .lk_hit   (line_hit),
      .lk_data  (line_data),
      .wr_en    (arr_wr_en),
      .wr_index (idx),
      .wr_tag   (tag),
      .wr_data  (arr_wr_data)
   );

   wtc_wbuf #(.WA_W(WA_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (store_en),
      .push_addr  (word_addr),
      .push_data  (cpu_wdata),
      .pop        (mem_wr_ack),
      .full       (wb_full),
      .empty      (wb_empty),
      .head_addr  (wb_head_addr),
      .head_data  (mem_wr_data),
      .probe_addr (word_addr),
      .probe_hit  (wb_hazard)
   );

   wtc_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_req      (cpu_req),
      .cpu_we       (cpu_we),
      .line_hit     (line_hit),
      .wb_full      (wb_full),
      .wb_hazard    (wb_hazard),
      .mem_rd_valid (mem_rd_valid),
      .cpu_stall    (cpu_stall),
      .fill_req     (fill_req),
      .install_en   (install_en),
      .store_en     (store_en)
   );

   assign cpu_rdata   = line_data;
   assign mem_rd_req  = fill_req;
   assign mem_rd_addr = {word_addr, {OFF_W{1'b0}}};
   assign mem_wr_req  = !wb_empty;
   assign mem_wr_addr = {wb_head_addr, {OFF_W{1'b0}}};

   AST_FILL_NO_HAZARD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !wb_hazard) else $error("fetch issued over pending store"); // R9
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)))
      else $error("fetch request dropped or moved"); // R3
   AST_FILL_INSTALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (install_en && cpu_req) |=> (!cpu_req || line_hit))
      else $error("fetched line not installed"); // R3

endmodule

// File: tb/dm_wt_cache_tb_top.sv
module dm_wt_cache_tb_top;

   localparam int IW    = 4;
   localparam int DEPTH = 4;
   localparam int RD_LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_stall;
   logic        mem_rd_req, mem_rd_valid;
   logic [31:0] mem_rd_addr, mem_rd_data;
   logic        mem_wr_req, mem_wr_ack;
   logic [31:0] mem_wr_addr, mem_wr_data;

   always #2 clk = ~clk;

   dm_wt_cache #(.ADDR_W(32), .DATA_W(32), .INDEX_W(IW), .WB_DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_wr_ack(mem_wr_ack)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   function automatic logic [31:0] init_word(input int w);
      return (32'(w) * 32'h9E3779B1) ^ 32'h5A5A0000;
   endfunction

   // memory model
   logic [31:0] mem     [256];
   logic [31:0] wlog_a  [64];
   logic [31:0] wlog_d  [64];
   int          wlog_n = 0;
   int          rd_served = 0;
   int          rd_cnt = 0, wr_cnt = 0;
   int          wr_lat = 2;

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = init_word(i);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_rd_valid <= 1'b0;
         mem_wr_ack   <= 1'b0;
         rd_cnt <= 0;
         wr_cnt <= 0;
      end else begin
         mem_rd_valid <= 1'b0;
         mem_wr_ack   <= 1'b0;
         if (mem_rd_req && !mem_rd_valid) begin
            if (rd_cnt >= RD_LAT - 1) begin
               mem_rd_valid <= 1'b1;
               mem_rd_data  <= mem[mem_rd_addr[9:2]];
               rd_cnt       <= 0;
               rd_served    <= rd_served + 1;
            end else rd_cnt <= rd_cnt + 1;
         end
         if (mem_wr_req && !mem_wr_ack) begin
            if (wr_cnt >= wr_lat - 1) begin
               mem_wr_ack <= 1'b1;
               mem[mem_wr_addr[9:2]] <= mem_wr_data;
               if (wlog_n < 64) begin
                  wlog_a[wlog_n] <= mem_wr_addr;
                  wlog_d[wlog_n] <= mem_wr_data;
               end
               wlog_n <= wlog_n + 1;
               wr_cnt <= 0;
            end else wr_cnt <= wr_cnt + 1;
         end
      end
   end

   // bench model of the cache and of architectural memory
   bit          mv [16];
   logic [25:0] mt [16];
   logic [31:0] refm [256];
   logic [31:0] exp_a [64];
   logic [31:0] exp_d [64];
   int          exp_n = 0;

   initial begin
      for (int i = 0; i < 256; i++) refm[i] = init_word(i);
      for (int i = 0; i < 16; i++) mv[i] = 1'b0;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int t, input int i);
      return {22'h0, 4'(t), 4'(i), 2'b00};
   endfunction

   function automatic bit model_hit(input logic [31:0] a);
      return mv[a[5:2]] && (mt[a[5:2]] == a[31:6]);
   endfunction

   task automatic acc(input bit we, input logic [31:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output int stalls, output int fills);
      int rd0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      stalls = 0;
      rd0 = rd_served;
      #1;
      while (cpu_stall && stalls < 5000) begin
         stalls++;
         @(negedge clk);
         #1;
      end
      rd = cpu_rdata;
      @(posedge clk);
      #1;
      cpu_req = 1'b0; cpu_we = 1'b0;
      fills = rd_served - rd0;
      mv[a[5:2]] = 1'b1;
      mt[a[5:2]] = a[31:6];
      if (we) begin
         refm[a[9:2]] = d;
         if (exp_n < 64) begin
            exp_a[exp_n] = {a[31:2], 2'b00};
            exp_d[exp_n] = d;
         end
         exp_n++;
      end
   endtask

   task automatic rd_chk(input logic [31:0] a, input string req);
      logic [31:0] rd; int st, fl; bit eh;
      eh = model_hit(a);
      acc(1'b0, a, '0, rd, st, fl);
      check(fl == (eh ? 0 : 1), req, eh ? "hit made a memory read" : "miss fetch count",
            32'(fl), eh ? 0 : 1);
      if (eh) check(st == 0, req, "hit stalled", 32'(st), 0);
      else    check(st > 0, req, "miss did not stall", 32'(st), 1);
      check(rd == refm[a[9:2]], req, "read data", rd, refm[a[9:2]]);
   endtask

   task automatic wr_chk(input logic [31:0] a, input logic [31:0] d, input string req);
      logic [31:0] rd; int st, fl; bit eh;
      eh = model_hit(a);
      acc(1'b1, a, d, rd, st, fl);
      check(fl == (eh ? 0 : 1), req, "store fetch count", 32'(fl), eh ? 0 : 1);
      if (eh) check(st == 0, req, "store hit stalled", 32'(st), 0);
   endtask

   task automatic drain_and_check_log(input string req);
      int guard = 0;
      while (wlog_n < exp_n && guard < 4000) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
      check(wlog_n == exp_n, req, "memory write count", 32'(wlog_n), 32'(exp_n));
      for (int i = 0; i < exp_n && i < 64; i++) begin
         check(wlog_a[i] == exp_a[i], req, "drain order address", wlog_a[i], exp_a[i]);
         check(wlog_d[i] == exp_d[i], req, "drain order data", wlog_d[i], exp_d[i]);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] rd;
      int st, fl;
      repeat (3) @(posedge clk);
      #1;
      check(mem_rd_req == 1'b0, "R2", "fetch request in reset", 32'(mem_rd_req), 0);
      check(mem_wr_req == 1'b0, "R2", "write request in reset", 32'(mem_wr_req), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(cpu_stall == 1'b0, "R2", "stall after reset", 32'(cpu_stall), 0);
      check(mem_rd_req == 1'b0 && mem_wr_req == 1'b0, "R2", "memory idle after reset",
            {30'b0, mem_rd_req, mem_wr_req}, 0);

      // cold sweep: every line misses once (R2, R3)
      for (int i = 0; i < 16; i++) rd_chk(mk(0, i), "R2");
      // hit sweep (R4)
      for (int i = 0; i < 16; i++) rd_chk(mk(0, i), "R4");
      // byte offset has no effect (R1)
      for (int i = 0; i < 16; i += 5)
         for (int b = 1; b < 4; b++) rd_chk(mk(0, i) | 32'(b), "R1");
      // top tag bit distinguishes lines (R1)
      rd_chk(mk(0, 3) | 32'h8000_0000, "R1");
      rd_chk(mk(0, 3), "R1");
      // conflicting tags evict each other (R10)
      for (int t = 1; t < 4; t++) begin
         rd_chk(mk(t, 7), "R10");
         rd_chk(mk(0, 7), "R10");
      end
      rd_chk(mk(0, 8), "R10");

      // store hits, then read back, then drain order (R5, R6)
      wr_lat = 2;
      for (int i = 0; i < 4; i++) wr_chk(mk(0, i), 32'hC0DE0000 + 32'(i), "R5");
      for (int i = 0; i < 4; i++) rd_chk(mk(0, i), "R5");
      drain_and_check_log("R6");

      // full queue stalls a store (R7)
      wr_lat = 40;
      for (int i = 0; i < DEPTH; i++) wr_chk(mk(0, 10 + i), 32'hF00D0000 + 32'(i), "R7");
      acc(1'b1, mk(0, 15), 32'hF00DFFFF, rd, st, fl);
      check(st > 0, "R7", "store to full queue did not stall", 32'(st), 1);
      check(fl == 0, "R7", "store hit to full queue fetched", 32'(fl), 0);
      rd_chk(mk(0, 15), "R7");
      drain_and_check_log("R7");
      wr_lat = 2;

      // store miss fetches then writes (R8)
      wr_chk(mk(5, 9), 32'h8BADF00D, "R8");
      rd_chk(mk(5, 9), "R8");
      wr_chk(mk(6, 2) | 32'h2, 32'h12345678, "R8");
      rd_chk(mk(6, 2), "R8");
      drain_and_check_log("R8");

      // fetch must wait for a pending store to the same word (R9)
      wr_lat = 30;
      wr_chk(mk(1, 5), 32'hDEADBEEF, "R9");
      rd_chk(mk(2, 5), "R9");
      rd_chk(mk(1, 5), "R9");
      drain_and_check_log("R9");
      wr_lat = 2;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule